// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt request pulses from twenty peripheral channels and one non-maskable source. Each request is held in its own pending flop. Every cycle the block picks the most urgent request and offers it to the processor as a registered triple: valid, level and vector. Software gives each channel a 3-bit level through a small register port. Levels 1 to 6 are live, and 0 or 7 silence the channel. The non-maskable source always outranks the others at level 7.

The processor takes a request by pulsing an acknowledge with the vector it accepted. That clears the matching pending flop. Software can also drop a pending request through the channel's keep bit. Four DMA slot registers each hold a vector. A pending, live channel whose vector sits in a slot is never offered to the processor. Instead, the block emits a one-cycle DMA start strobe tagged with the slot number and retires the request itself.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every pending flag, channel level and DMA slot reads zero, and `irq_valid` and `dma_start` are low.
- R2: A request pulse on `irq_req[n]` sets that channel's pending flag at the next clock edge. One edge later, `irq_valid`, `irq_level` and `irq_vector` present it, with vector 0x20 + 4·n.
- R3: A pending channel whose level is 0 or 7 is never presented. Its flag stays set and can still be read.
- R4: Among live pending channels, the one with the numerically highest level is presented.
- R5: When live pending channels share the top level, the lowest channel number, which is also the lowest vector, is presented.
- R6: A pulse on `nmi_req` is held pending and presented at level 7 with vector 0x08, ahead of every channel. An acknowledge carrying 0x08 clears it.
- R7: An `ack` pulse clears the pending flag of the source whose vector equals `ack_vec`, and no other.
- R8: Channel register n sits at address n (0 to 19). A write stores `wr_data[2:0]` as the level. It clears the pending flag when `wr_data[3]` is 0 and leaves the flag alone when that bit is 1.
- R9: Reading channel address n returns pending in bit 3 and the level in bits 2:0, with bits 7:4 at zero.
- R10: A request arriving in the same cycle as any clear of that channel wins, so the flag stays set.
- R11: DMA slot s sits at address 0x20 + s, reads back as written, and holds a vector. When a pending channel with a live level matches a slot, `dma_start` pulses for one cycle, one edge after the flag is set, with `dma_slot` = s. The flag clears on that same edge, and the channel is not presented to the processor.
- R12: A DMA slot holding 0 matches nothing, so the channel is presented to the processor as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 20 | Per-channel request pulses |
| nmi_req | input | 1 | Non-maskable request pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ack | input | 1 | Processor acknowledge pulse |
| ack_vec | input | 8 | Vector being acknowledged |
| irq_valid | output | 1 | A request is being offered |
| irq_level | output | 3 | Level of the offered request |
| irq_vector | output | 8 | Vector of the offered request |
| dma_start | output | 1 | One-cycle DMA start strobe |
| dma_slot | output | 2 | Slot that raised the strobe |

## Verification
A pending flop stuck high or dropped shows at the read port on the very next cycle. It also shows on the offered vector one edge later, because it either hides a lower-ranked request or leaves a gap after an acknowledge. A wrong comparison in the arbiter shows as the wrong vector two edges after the request pulse. Mis-routing to DMA shows in that same cycle, as a strobe alongside a processor request or in place of one. The directed scenarios lay out channel levels so that each of these faults produces a different vector from the expected one.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  localparam int VEC_W = 8;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [VEC_W-1:0] vec_t;

  // Vector of channel n: base plus four per channel.
  function automatic vec_t chan_vector(input vec_t base, input int unsigned n);
    return base + VEC_W'(n * 4);
  endfunction

  // Levels 1..6 take part in arbitration; 0 and 7 mute a channel.
  function automatic logic lvl_live(input lvl_t l);
    return (l != '0) && (l != '1);
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_pkg::*;
#(
  parameter int NCH = 20,
  parameter int AW = 6,
  parameter vec_t VBASE = 8'h20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  input  logic           ack,
  input  vec_t           ack_vec,
  input  logic [NCH-1:0] dma_clr,
  output logic [NCH-1:0] pend,
  output lvl_t           lvl [NCH]
);
  logic [NCH-1:0] clr;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_hit, sw_clr, ack_clr;
    assign wr_hit  = wr_en && (wr_addr == AW'(i));
    assign sw_clr  = wr_hit && !wr_data[3];
    assign ack_clr = ack && (ack_vec == chan_vector(VBASE, i));
    assign clr[i]  = sw_clr | ack_clr | dma_clr[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        lvl[i]  <= '0;
      end else begin
        pend[i] <= req[i] | (pend[i] & ~clr[i]);
        if (wr_hit) lvl[i] <= wr_data[LVL_W-1:0];
      end
    end
  end

  // A fresh request always lands, even against a clear (R10).
  assert_req_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(req)) == $past(req)));
  // A flag with no request and no clear keeps its value (R7).
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0 && clr == '0) |=> $stable(pend));
endmodule

// File: rtl/irq_dma_route.sv
module irq_dma_route
  import irq_pkg::*;
#(
  parameter int NCH = 20,
  parameter int NDMA = 4,
  parameter int AW = 6,
  parameter int DMA_ADDR = 32,
  parameter vec_t VBASE = 8'h20,
  localparam int SW = $clog2(NDMA),
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [NCH-1:0] pend,
  input  lvl_t           lvl [NCH],
  output logic [NCH-1:0] route,
  output logic [NCH-1:0] dma_clr,
  output logic           fire,
  output logic [SW-1:0]  fire_slot,
  output vec_t           slot_vec [NDMA]
);
  logic [SW-1:0] ch_slot [NCH];
  logic [IW-1:0] fire_ch;

  for (genvar s = 0; s < NDMA; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_vec[s] <= '0;
      else if (wr_en && wr_addr == AW'(DMA_ADDR + s)) slot_vec[s] <= wr_data;
    end
  end

  // Per channel: does any live slot hold its vector, and which one first.
  for (genvar i = 0; i < NCH; i++) begin : g_match
    always_comb begin
      route[i]   = 1'b0;
      ch_slot[i] = '0;
      for (int s = NDMA - 1; s >= 0; s--) begin
        if (slot_vec[s] != '0 && slot_vec[s] == chan_vector(VBASE, i)) begin
          route[i]   = 1'b1;
          ch_slot[i] = SW'(s);
        end
      end
    end
  end

  // Lowest ready routed channel fires this cycle.
  always_comb begin
    fire    = 1'b0;
    fire_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (route[i] && pend[i] && lvl_live(lvl[i])) begin
        fire    = 1'b1;
        fire_ch = IW'(i);
      end
    end
    fire_slot = ch_slot[fire_ch];
    dma_clr   = '0;
    if (fire) dma_clr[fire_ch] = 1'b1;
  end

  assert_dma_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dma_clr));
  assert_dma_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (pend[fire_ch] && route[fire_ch]));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NCH = 20,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend,
  input  lvl_t           lvl [NCH],
  input  logic [NCH-1:0] route,
  output logic           win_valid,
  output logic [IW-1:0]  win_idx,
  output lvl_t           win_lvl
);
  // Ascending scan with strict compare: ties stay with the lowest index.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (pend[i] && !route[i] && lvl_live(lvl[i]) && lvl[i] > win_lvl) begin
        win_valid = 1'b1;
        win_idx   = IW'(i);
        win_lvl   = lvl[i];
      end
    end
  end

  assert_win_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (pend[win_idx] && lvl_live(lvl[win_idx])));
  assert_win_not_dma_R11: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> !route[win_idx]);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NCH = 20,
  parameter int NDMA = 4,
  parameter int AW = 6,
  parameter int DMA_ADDR = 32,
  parameter logic [7:0] VBASE = 8'h20,
  parameter logic [7:0] NMI_VEC = 8'h08,
  localparam int SW = $clog2(NDMA),
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] irq_req,
  input  logic           nmi_req,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [7:0]     rd_data,
  input  logic           ack,
  input  logic [7:0]     ack_vec,
  output logic           irq_valid,
  output logic [2:0]     irq_level,
  output logic [7:0]     irq_vector,
  output logic           dma_start,
  output logic [SW-1:0]  dma_slot
);
  logic [NCH-1:0] pend, route, dma_clr;
  lvl_t           lvl [NCH];
  vec_t           slot_vec [NDMA];
  logic           fire, win_valid, nmi_pend;
  logic [SW-1:0]  fire_slot;
  logic [IW-1:0]  win_idx;
  lvl_t           win_lvl;

  irq_pend_bank #(.NCH(NCH), .AW(AW), .VBASE(VBASE)) u_bank (
    .clk, .rst_n, .req(irq_req), .wr_en, .wr_addr, .wr_data,
    .ack, .ack_vec, .dma_clr, .pend, .lvl
  );

  irq_dma_route #(.NCH(NCH), .NDMA(NDMA), .AW(AW), .DMA_ADDR(DMA_ADDR),
                  .VBASE(VBASE)) u_dma (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .pend, .lvl,
    .route, .dma_clr, .fire, .fire_slot, .slot_vec
  );

  irq_arbiter #(.NCH(NCH)) u_arb (
    .clk, .rst_n, .pend, .lvl, .route, .win_valid, .win_idx, .win_lvl
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_pend <= 1'b0;
    else nmi_pend <= nmi_req | (nmi_pend & ~(ack && ack_vec == NMI_VEC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_level  <= '0;
      irq_vector <= '0;
      dma_start  <= 1'b0;
      dma_slot   <= '0;
    end else begin
      irq_valid  <= nmi_pend | win_valid;
      irq_level  <= nmi_pend ? 3'd7 : (win_valid ? win_lvl : 3'd0);
      irq_vector <= nmi_pend ? NMI_VEC
                  : (win_valid ? chan_vector(VBASE, int'(win_idx)) : 8'h00);
      dma_start  <= fire;
      dma_slot   <= fire_slot;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NCH; i++)
      if (rd_addr == AW'(i)) rd_data = {4'b0, pend[i], lvl[i]};
    for (int s = 0; s < NDMA; s++)
      if (rd_addr == AW'(DMA_ADDR + s)) rd_data = slot_vec[s];
  end

  assert_nmi_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |=> (irq_valid && irq_level == 3'd7 && irq_vector == NMI_VEC));
  assert_level_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_level != 3'd0);
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0 && !nmi_pend) |=> !irq_valid);
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [19:0] irq_req = '0;
  logic        nmi_req = 1'b0, wr_en = 1'b0, ack = 1'b0;
  logic [5:0]  wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0, ack_vec = '0, rd_data, irq_vector;
  logic        irq_valid, dma_start;
  logic [2:0]  irq_level;
  logic [1:0]  dma_slot;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_prio_ctrl dut (
    .clk, .rst_n, .irq_req, .nmi_req, .wr_en, .wr_addr, .wr_data,
    .rd_addr, .rd_data, .ack, .ack_vec, .irq_valid, .irq_level,
    .irq_vector, .dma_start, .dma_slot
  );

  function automatic logic [7:0] vec_of(input int n);
    return 8'h20 + 8'(4 * n);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = 8'(d);
    tick(); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 6'(a); #1; d = int'(rd_data);
  endtask

  task automatic pulse(input logic [19:0] m);
    irq_req = m; tick(); irq_req = '0; tick();
  endtask

  task automatic do_ack(input int v);
    ack = 1'b1; ack_vec = 8'(v); tick(); ack = 1'b0; tick();
  endtask

  task automatic chk_out(input string req, input int v, input int l, input int vec);
    chk(req, int'(irq_valid), v);
    if (v != 0) begin
      chk(req, int'(irq_level), l);
      chk(req, int'(irq_vector), vec);
    end
  endtask

  task automatic t_reset();
    int d;
    rd(0, d);  chk("R1 ch0", d, 0);
    rd(19, d); chk("R1 ch19", d, 0);
    rd(32, d); chk("R1 slot0", d, 0);
    chk("R1 valid", int'(irq_valid), 0);
    chk("R1 dma", int'(dma_start), 0);
  endtask

  task automatic t_single();
    int d;
    wr(5, 8'h0B);
    pulse(20'(1) << 5);
    chk_out("R2 single", 1, 3, vec_of(5));
    rd(5, d); chk("R9 read", d, 8'h0B);
    do_ack(vec_of(5));
    chk_out("R7 ack", 0, 0, 0);
    rd(5, d); chk("R7 cleared", d, 8'h03);
    wr(5, 0);
  endtask

  task automatic t_disable();
    int d;
    wr(2, 8'h08);
    pulse(20'(1) << 2);
    chk_out("R3 lvl0", 0, 0, 0);
    rd(2, d); chk("R3 still pending", d, 8'h08);
    wr(2, 8'h0F); tick();
    chk_out("R3 lvl7", 0, 0, 0);
    wr(2, 8'h07);
    rd(2, d); chk("R8 sw clear", d, 8'h07);
    wr(2, 0);
  endtask

  task automatic t_priority();
    wr(3, 8'h0A); wr(10, 8'h0D); wr(15, 8'h0C);
    pulse((20'(1) << 3) | (20'(1) << 10) | (20'(1) << 15));
    chk_out("R4 highest", 1, 5, vec_of(10));
    do_ack(vec_of(10));
    chk_out("R4 next", 1, 4, vec_of(15));
    do_ack(vec_of(15));
    chk_out("R4 last", 1, 2, vec_of(3));
    wr(3, 0); tick();
    chk_out("R8 cleared all", 0, 0, 0);
    wr(10, 0); wr(15, 0);
  endtask

  task automatic t_tie();
    wr(7, 8'h0C); wr(12, 8'h0C);
    pulse((20'(1) << 7) | (20'(1) << 12));
    chk_out("R5 tie", 1, 4, vec_of(7));
    do_ack(vec_of(7));
    chk_out("R5 second", 1, 4, vec_of(12));
    wr(7, 0); wr(12, 0);
  endtask

  task automatic t_nmi();
    wr(1, 8'h0E);
    irq_req = 20'(1) << 1; nmi_req = 1'b1; tick();
    irq_req = '0; nmi_req = 1'b0; tick();
    chk_out("R6 nmi", 1, 7, 8'h08);
    do_ack(8'h08);
    chk_out("R6 after nmi", 1, 6, vec_of(1));
    wr(1, 0);
  endtask

  task automatic t_collide();
    int d;
    wr(4, 8'h09);
    pulse(20'(1) << 4);
    irq_req = 20'(1) << 4; wr_en = 1'b1; wr_addr = 6'd4; wr_data = 8'h01;
    tick(); irq_req = '0; wr_en = 1'b0;
    rd(4, d); chk("R10 req beats clear", d, 8'h09);
    tick();
    chk_out("R10 presented", 1, 1, vec_of(4));
    wr(4, 0);
  endtask

  task automatic t_dma();
    int d;
    wr(33, vec_of(9));
    rd(33, d); chk("R11 slot readback", d, vec_of(9));
    wr(9, 8'h0B);
    irq_req = 20'(1) << 9; tick(); irq_req = '0;
    chk("R11 no early strobe", int'(dma_start), 0);
    tick();
    chk("R11 strobe", int'(dma_start), 1);
    chk("R11 slot", int'(dma_slot), 1);
    chk("R11 no cpu", int'(irq_valid), 0);
    tick();
    chk("R11 one cycle", int'(dma_start), 0);
    chk("R11 no cpu later", int'(irq_valid), 0);
    rd(9, d); chk("R11 flag retired", d, 8'h03);
  endtask

  task automatic t_dma_off();
    wr(33, 0);
    pulse(20'(1) << 9);
    chk("R12 no strobe", int'(dma_start), 0);
    chk_out("R12 to cpu", 1, 3, vec_of(9));
    wr(9, 0);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_disable();
    t_priority();
    t_tie();
    t_nmi();
    t_collide();
    t_dma();
    t_dma_off();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule